// File: doc/BRIEF.md
# Configuration reset handshake sequencer

This block clears and re-arms a programmable-logic fabric before a new configuration is loaded. It owns the fabric's active-low program pin and watches the fabric's init status line. The clear runs in three phases. First the pin is released, and the sequencer waits for init to read high. Then the pin is pulled low, and init is polled at a fixed cadence until it reads low. Finally the pin is released again, and the sequencer waits for init to come back high. That last rise means the fabric has finished its internal initialisation.

A one-cycle `start` launches the sequence. `busy` stays high while it runs. The sequence ends with a one-cycle `seqDone` or `seqErr` and then returns to idle. The two rise waits are bounded by a cycle timeout. The low-pulse wait is bounded by a poll count. The block also keeps a sticky record of the fabric's configuration-done signal. It clears that record at each phase boundary, so that a later done can only come from the new configuration.

Top module: `cfg_reset_seq`

## Requirements
- R1: After reset, `progN` is 1 and `busy`, `seqDone`, `seqErr` and `doneSticky` are 0.
- R2: A `start` seen while idle sets `busy` on the next cycle, with `progN` still held at 1 (released).
- R3: If the synchronised init is already high when the sequence begins, `progN` goes low on the cycle after `busy` rises. No init edge is needed.
- R4: `initIn` passes through a two-flop synchroniser. If it rises `a` cycles after `busy` is first seen (a <= TIMEOUT-3), `progN` goes low `a`+3 cycles after that point.
- R5: If init stays low in the first phase, `seqErr` pulses TIMEOUT cycles after `busy` is first seen, and `progN` stays 1.
- R6: While `progN` is low, init is sampled once every POLL_GAP cycles. If `initIn` falls `d` cycles after the pin fall, the pin stays low for POLL_GAP*ceil((d+3)/POLL_GAP) cycles, provided that ceiling is at most POLL_LIMIT.
- R7: If none of the POLL_LIMIT polls sees init low, `seqErr` pulses POLL_LIMIT*POLL_GAP cycles after the pin fall, and `progN` returns to 1 on the same cycle.
- R8: After the second release, if `initIn` rises `r` cycles later (r <= TIMEOUT-3), `seqDone` pulses `r`+3 cycles after the release.
- R9: If init does not rise after the second release, `seqErr` pulses TIMEOUT cycles after the release.
- R10: `doneSticky` is set by any cycle with `cfgDoneIn` high and holds until cleared. It is cleared at start, when the pin is released after the low pulse, and when the final init rise is taken. A `cfgDoneIn` high in the same cycle as a clear is kept.
- R11: `seqDone` and `seqErr` last one cycle. On the next cycle `busy` is 0 and `progN` is 1.
- R12: A `start` that arrives while `busy` is high has no effect on the running sequence or its timing, and it does not begin a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| start | input | 1 | One-cycle request to run the sequence |
| initIn | input | 1 | Fabric init status, asynchronous |
| cfgDoneIn | input | 1 | Fabric configuration-done level, synchronous to clk |
| progN | output | 1 | Active-low program pin to the fabric |
| busy | output | 1 | Sequence in progress |
| seqDone | output | 1 | One-cycle pulse: sequence completed |
| seqErr | output | 1 | One-cycle pulse: a wait expired |
| doneSticky | output | 1 | Sticky record of cfgDoneIn |

## Verification
The assertions make three assumptions about the inputs. `cfgDoneIn` and `start` are synchronous to `clk`. `initIn` only matters through its synchronised copy. The fabric never drives init before the pin it answers to has moved. The stimulus follows a fabric-like script to stay within these assumptions. Every input changes on the falling edge. Init is raised only while the pin is released and lowered only while it is pulled. Each phase's response delay is swept across the whole range from immediate to past its bound, so both the success timing and the expiry timing are compared against closed-form cycle counts.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  // depth of the init synchroniser
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT_UP1,
    SEQ_PULSE,
    SEQ_WAIT_UP2,
    SEQ_FINISH,
    SEQ_FAIL
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic pinRelease;
    logic pinAssert;
    logic clrSticky;
    logic cntClear;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic initHi;
    logic pollNow;
    logic lastPoll;
    logic timedOut;
  } seqStatus_t;

endpackage

// File: rtl/cfg_seq_dp.sv
module cfg_seq_dp
  import cfg_seq_pkg::*;
#(
  parameter int POLL_GAP   = 500,
  parameter int POLL_LIMIT = 100,
  parameter int TIMEOUT    = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initIn,
  input  logic       cfgDoneIn,
  input  seqStrobe_t strobe,
  output seqStatus_t status,
  output logic       progN,
  output logic       doneSticky
);

  localparam int GAP_W  = (POLL_GAP   > 1) ? $clog2(POLL_GAP)   : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int WAIT_W = (TIMEOUT    > 1) ? $clog2(TIMEOUT)    : 1;
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(POLL_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT - 1);

  // init synchroniser
  logic [SYNC_DEPTH-1:0] syncReg;
  logic initSync;

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_DEPTH-2:0], initIn};
  end
  assign initSync = syncReg[SYNC_DEPTH-1];

  // poll cadence and poll count
  logic [GAP_W-1:0]  gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic pollNow, lastPoll, timedOut;

  assign pollNow  = (gapCnt == GAP_LAST);
  assign lastPoll = (pollCnt == POLL_LAST);
  assign timedOut = (waitCnt == WAIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear) gapCnt <= '0;
    else if (pollNow)             gapCnt <= '0;
    else                          gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear)  pollCnt <= '0;
    else if (pollNow && !lastPoll) pollCnt <= pollCnt + 1'b1;
  end

  // rise-wait timeout, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear) waitCnt <= '0;
    else if (!timedOut)           waitCnt <= waitCnt + 1'b1;
  end

  // program pin, released at reset
  always_ff @(posedge clk) begin
    if (!rstN)                  progN <= 1'b1;
    else if (strobe.pinAssert)  progN <= 1'b0;
    else if (strobe.pinRelease) progN <= 1'b1;
  end

  // sticky config-done: a done in the clearing cycle is kept
  always_ff @(posedge clk) begin
    if (!rstN) doneSticky <= 1'b0;
    else       doneSticky <= (doneSticky & ~strobe.clrSticky) | cfgDoneIn;
  end

  assign status = '{initHi: initSync, pollNow: pollNow,
                    lastPoll: lastPoll, timedOut: timedOut};

  // pin only falls after init was seen high
  assert_pin_fall_needs_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progN) |-> $past(initSync));

  // poll counter stays inside its limit
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_LAST);

  // sticky flag only drops on a clear strobe
  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneSticky && !strobe.clrSticky |=> doneSticky);

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       seqDone,
  output logic       seqErr
);

  seqState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (start) begin
          stateNext         = SEQ_WAIT_UP1;
          strobe.pinRelease = 1'b1;
          strobe.clrSticky  = 1'b1;
          strobe.cntClear   = 1'b1;
        end
      end
      SEQ_WAIT_UP1: begin
        if (status.initHi) begin
          stateNext        = SEQ_PULSE;
          strobe.pinAssert = 1'b1;
          strobe.cntClear  = 1'b1;
        end else if (status.timedOut) begin
          stateNext         = SEQ_FAIL;
          strobe.pinRelease = 1'b1;
        end
      end
      SEQ_PULSE: begin
        if (status.pollNow) begin
          if (!status.initHi) begin
            stateNext         = SEQ_WAIT_UP2;
            strobe.pinRelease = 1'b1;
            strobe.clrSticky  = 1'b1;
            strobe.cntClear   = 1'b1;
          end else if (status.lastPoll) begin
            stateNext         = SEQ_FAIL;
            strobe.pinRelease = 1'b1;
          end
        end
      end
      SEQ_WAIT_UP2: begin
        if (status.initHi) begin
          stateNext        = SEQ_FINISH;
          strobe.clrSticky = 1'b1;
        end else if (status.timedOut) begin
          stateNext         = SEQ_FAIL;
          strobe.pinRelease = 1'b1;
        end
      end
      SEQ_FINISH: stateNext = SEQ_IDLE;
      SEQ_FAIL:   stateNext = SEQ_IDLE;
      default:    stateNext = SEQ_IDLE;
    endcase
  end

  assign busy    = (state != SEQ_IDLE);
  assign seqDone = (state == SEQ_FINISH);
  assign seqErr  = (state == SEQ_FAIL);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone && !busy);

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> !seqErr && !busy);

  assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy && !seqDone && !seqErr |=> busy);

endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq
  import cfg_seq_pkg::*;
#(
  parameter int POLL_GAP   = 500,
  parameter int POLL_LIMIT = 100,
  parameter int TIMEOUT    = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic initIn,
  input  logic cfgDoneIn,
  output logic progN,
  output logic busy,
  output logic seqDone,
  output logic seqErr,
  output logic doneSticky
);

  seqStrobe_t strobe;
  seqStatus_t status;

  cfg_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .status  (status),
    .strobe  (strobe),
    .busy    (busy),
    .seqDone (seqDone),
    .seqErr  (seqErr)
  );

  cfg_seq_dp #(
    .POLL_GAP   (POLL_GAP),
    .POLL_LIMIT (POLL_LIMIT),
    .TIMEOUT    (TIMEOUT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .initIn     (initIn),
    .cfgDoneIn  (cfgDoneIn),
    .strobe     (strobe),
    .status     (status),
    .progN      (progN),
    .doneSticky (doneSticky)
  );

endmodule

// File: tb/sim_cfg_reset_seq.sv
module sim_cfg_reset_seq;

  localparam int GAP = 3;
  localparam int LIM = 4;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic initIn = 1'b0;
  logic cfgDoneIn = 1'b0;
  logic progN, busy, seqDone, seqErr, doneSticky;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_reset_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIM), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .initIn(initIn),
    .cfgDoneIn(cfgDoneIn), .progN(progN), .busy(busy),
    .seqDone(seqDone), .seqErr(seqErr), .doneSticky(doneSticky)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ceilDiv(input int x, input int y);
    return (x + y - 1) / y;
  endfunction

  // after a done or error pulse: one cycle only, back to idle (R11, R12)
  task automatic tail();
    @(negedge clk);
    chkEq("R11 pulse length", int'(seqDone | seqErr), 0);
    chkEq("R11 idle after end", int'(busy), 0);
    chkEq("R11 pin released", int'(progN), 1);
    @(negedge clk);
    chkEq("R12 no restart from busy start", int'(busy), 0);
  endtask

  // a<0: init already high; otherwise cycles until each fabric response
  task automatic runSeq(input int a, input int d, input int r, input bit holdDone);
    int c, expC, k;
    bit expErr;
    @(negedge clk);
    initIn = (a < 0);
    cfgDoneIn = 1'b1;
    @(negedge clk);
    cfgDoneIn = holdDone;
    repeat (3) @(negedge clk);
    chkEq("R10 sticky set while idle", int'(doneSticky), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfgDoneIn = 1'b0;
    chkEq("R2 busy after start", int'(busy), 1);
    chkEq("R2 pin released first", int'(progN), 1);
    chkEq("R10 clear at start", int'(doneSticky), holdDone ? 1 : 0);

    // phase one
    c = 0;
    while (progN && !seqErr && c < 1000) begin
      if (a >= 0 && c == a) initIn = 1'b1;
      @(negedge clk);
      c++;
    end
    if (a < 0) begin expC = 1; expErr = 0; end
    else if (a <= TMO - 3) begin expC = a + 3; expErr = 0; end
    else begin expC = TMO; expErr = 1; end
    if (a < 0)       chkEq("R3 already-high pin fall", c, expC);
    else if (expErr) chkEq("R5 first-phase timeout", c, expC);
    else             chkEq("R4 synchronised rise", c, expC);
    chkEq("R5 error flag phase one", int'(seqErr), int'(expErr));
    if (seqErr) begin
      chkEq("R5 pin stays high", int'(progN), 1);
      tail();
      return;
    end

    // phase two: pin low, polled
    c = 0;
    while (!progN && !seqErr && c < 1000) begin
      if (c == d) initIn = 1'b0;
      if (c == 1) cfgDoneIn = 1'b1;
      if (c == 2) begin
        cfgDoneIn = 1'b0;
        chkEq("R10 sticky set in pulse", int'(doneSticky), 1);
      end
      @(negedge clk);
      c++;
    end
    k = ceilDiv(d + 3, GAP);
    if (k <= LIM) begin
      chkEq("R6 pulse width", c, k * GAP);
      chkEq("R6 no error", int'(seqErr), 0);
      chkEq("R10 clear on release", int'(doneSticky), 0);
    end else begin
      chkEq("R7 poll limit error time", c, LIM * GAP);
      chkEq("R7 error flag", int'(seqErr), 1);
    end
    chkEq("R7 pin high after pulse", int'(progN), 1);
    if (seqErr) begin
      tail();
      return;
    end

    // phase three: wait for rise; stray start while busy
    c = 0;
    while (!seqDone && !seqErr && c < 1000) begin
      if (c == r) initIn = 1'b1;
      if (c == 0) start = 1'b1;
      if (c == 1) begin start = 1'b0; cfgDoneIn = 1'b1; end
      if (c == 2) cfgDoneIn = 1'b0;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    cfgDoneIn = 1'b0;
    if (r <= TMO - 3) begin
      chkEq("R8 done timing", c, r + 3);
      chkEq("R8 done flag", int'(seqDone), 1);
      chkEq("R10 clear at final rise", int'(doneSticky), 0);
    end else begin
      chkEq("R9 final timeout", c, TMO);
      chkEq("R9 error flag", int'(seqErr), 1);
    end
    tail();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chkEq("R1 reset pin", int'(progN), 1);
    chkEq("R1 reset busy", int'(busy), 0);
    chkEq("R1 reset pulses", int'(seqDone | seqErr), 0);
    chkEq("R1 reset sticky", int'(doneSticky), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int a = -1; a <= TMO; a++) runSeq(a, 0, 0, 1'b0);
    for (int d = 0; d <= LIM * GAP; d++) runSeq(-1, d, 0, 1'b0);
    for (int r = 0; r <= TMO + 1; r++) runSeq(-1, 0, r, 1'b0);
    runSeq(-1, 1, 1, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule